// File: doc/BRIEF.md
# Twisted-Ring Edge Counter Sampler

This block is the digital back end of a delay-based supply-voltage sensor. A fast free-running clock, in place of a ring oscillator output, advances a chain of flip-flops wired as a twisted ring (Johnson counter). The chain has no gates between stages, so it tolerates clock rates far above those a binary counter could handle. A slower, unrelated sampling clock brings the ring state into its own domain through a short synchronizer. It decodes that state into a position and reports how many fast-clock edges occurred between two consecutive samples.

The edge count per sample period tracks the oscillator frequency, and that frequency in turn follows the local supply voltage. Because a ring of N stages has only 2N states, the count is exact only while a sampling period spans fewer than 2N oscillator periods. Beyond that it aliases modulo 2N. A phase offset between the two clocks can make a single difference one higher or lower than the true average. The twisted ring changes exactly one bit per edge, so a sample taken mid-transition still resolves to one of two adjacent legal states. Many instances are meant to be summed downstream.

Top module: `ring_edge_sampler`

## Requirements
- R1: An active-high synchronous oscillator-domain reset forces every ring stage to 0, and the ring counts up from position 0 once reset is released.
- R2: On each oscillator rising edge outside reset, the ring shifts one place toward the last stage, and stage 0 loads the inverse of the last stage. Exactly one bit changes per edge, and the ring cycles through 2*STAGES states.
- R3: A captured state is decoded by its bit-0 value and the length r of the run of equal bits that starts at bit 0. If bit 0 is 1, the index is r. If bit 0 is 0, the index is (STAGES + r) mod 2*STAGES. For example, with 8 stages, 0x00 gives 0, 0x01 gives 1, 0xFF gives 8, 0xFE gives 9 and 0x80 gives 15. The index therefore equals the number of oscillator edges since the ring was reset, modulo 2*STAGES.
- R4: `stageIndex` shows the ring state captured at sample edge n once edge n+SYNC_DEPTH has passed (2 sample clocks by default). Captures from before the sampling reset count as index 0.
- R5: While `deltaValid` is high, `edgeDelta` equals the present `stageIndex` minus the previous `stageIndex`, modulo 2*STAGES. This is the number of oscillator edges between the two captures, modulo 2*STAGES.
- R6: After a sampling-domain reset, `deltaValid` and `edgeDelta` stay at 0 up to and including sample edge SYNC_DEPTH+1 (edge 3 by default). From edge SYNC_DEPTH+2 (edge 4 by default) on, `deltaValid` is high on every sample edge until the next reset.
- R7: `codeError` is high when the captured state has more than one place where adjacent bits differ, which is a state outside the 2*STAGES legal codes. It is low for every legal code.
- R8: When a sampling period holds 2*STAGES or more oscillator edges, `edgeDelta` reports the edge count modulo 2*STAGES without error.
- R9: An oscillator-domain reset during operation returns `stageIndex` to 0 through the normal capture path. It does not disturb `deltaValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Fast free-running clock that advances the ring |
| oscRst | input | 1 | Active-high synchronous reset, oscillator domain |
| smpClk | input | 1 | Sampling clock, unrelated in phase to oscClk |
| smpRst | input | 1 | Active-high synchronous reset, sampling domain |
| stageIndex | output | $clog2(2*STAGES) | Decoded position of the latest captured ring state |
| edgeDelta | output | $clog2(2*STAGES) | Oscillator edges between the last two captures, modulo 2*STAGES |
| deltaValid | output | 1 | High when edgeDelta holds a difference of two real captures |
| codeError | output | 1 | Latest captured ring state is not a legal twisted-ring code |

## Verification
The hardest case to reach is a sampling period that holds 2*STAGES or more oscillator edges, where the difference wraps. The stimulus reaches it by shortening the behavioural oscillator period to 0.6 ns and then to 0.5 ns against a 10 ns sample period. A second hard case is an oscillator reset partway through a run, which makes the count step backwards; a pulse on the oscillator reset alone produces it. Every oscillator edge is placed on a fixed sub-grid that never coincides with a sampling edge. This keeps each capture deterministic, so the bench model can predict every index exactly as the oscillator period varies from 0.5 ns to 10 ns.

// File: rtl/ring_sense_pkg.sv
`timescale 1ns/1ps
package ring_sense_pkg;

  // Strobes from the sampling-side control to the datapath.
  typedef struct packed {
    logic capEn;   // take a new output update this edge
    logic armed;   // pipeline holds two real captures; differences are meaningful
  } smpCtrl_t;

endpackage

// File: rtl/twisted_ring.sv
`timescale 1ns/1ps
// Johnson chain clocked by the fast oscillator. No logic between stages
// apart from the single inversion on the feedback into stage 0.
module twisted_ring #(
  parameter int STAGES = 8
) (
  input  logic              oscClk,
  input  logic              oscRst,
  output logic [STAGES-1:0] ringState
);

  always_ff @(posedge oscClk) begin
    if (oscRst) ringState <= '0;
    else        ringState <= {ringState[STAGES-2:0], ~ringState[STAGES-1]};
  end

endmodule

// File: rtl/sense_control.sv
`timescale 1ns/1ps
// Sampling-domain warm-up: counts edges after reset until the first two
// real captures have crossed the synchronizer.
module sense_control
  import ring_sense_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic     smpClk,
  input  logic     smpRst,
  output smpCtrl_t ctrl,
  output logic     deltaValid
);

  localparam int LAT  = SYNC_DEPTH + 1;
  localparam int CNTW = $clog2(LAT + 1);

  logic [CNTW-1:0] warmCnt;
  logic            warmDone;

  assign warmDone = (warmCnt == CNTW'(LAT));

  always_ff @(posedge smpClk) begin
    if (smpRst) begin
      warmCnt    <= '0;
      deltaValid <= 1'b0;
    end else begin
      if (!warmDone) warmCnt <= warmCnt + 1'b1;
      deltaValid <= warmDone;
    end
  end

  assign ctrl.capEn = ~smpRst;
  assign ctrl.armed = warmDone;

endmodule

// File: rtl/sense_datapath.sv
`timescale 1ns/1ps
// Synchronizer, twisted-ring decode and modulo difference.
module sense_datapath
  import ring_sense_pkg::*;
#(
  parameter int STAGES     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                            smpClk,
  input  logic                            smpRst,
  input  logic [STAGES-1:0]               ringAsync,
  input  smpCtrl_t                        ctrl,
  output logic [$clog2(2*STAGES)-1:0]     stageIndex,
  output logic [$clog2(2*STAGES)-1:0]     edgeDelta,
  output logic                            codeError
);

  localparam int IDXW = $clog2(2 * STAGES);
  localparam int MODN = 2 * STAGES;
  localparam int RUNW = $clog2(STAGES + 1);

  // Synchronizer: only one ring bit moves between adjacent states, so a
  // capture on a transition lands on one of two neighbouring codes.
  logic [STAGES-1:0] syncOut;

  for (genvar g = 0; g < SYNC_DEPTH; g++) begin : gSync
    logic [STAGES-1:0] q;
    if (g == 0) begin : gFirst
      always_ff @(posedge smpClk) begin
        if (smpRst) q <= '0;
        else        q <= ringAsync;
      end
    end else begin : gNext
      always_ff @(posedge smpClk) begin
        if (smpRst) q <= '0;
        else        q <= gSync[g-1].q;
      end
    end
  end

  assign syncOut = gSync[SYNC_DEPTH-1].q;

  // Decode: run of bits equal to bit 0, plus a legality count of edges
  // between adjacent bits.
  logic [RUNW-1:0] runLen;
  logic [RUNW-1:0] flipCnt;
  logic            inRun;
  logic [IDXW-1:0] idxNow;
  logic            legalNow;

  always_comb begin
    runLen  = '0;
    flipCnt = '0;
    inRun   = 1'b1;
    for (int i = 0; i < STAGES; i++) begin
      if (inRun && (syncOut[i] == syncOut[0])) runLen = runLen + 1'b1;
      else                                     inRun  = 1'b0;
    end
    for (int i = 0; i < STAGES - 1; i++) begin
      if (syncOut[i] != syncOut[i+1]) flipCnt = flipCnt + 1'b1;
    end
    legalNow = (flipCnt <= RUNW'(1));
    if (syncOut[0])                    idxNow = IDXW'(runLen);
    else if (runLen == RUNW'(STAGES))  idxNow = '0;
    else                               idxNow = IDXW'(STAGES) + IDXW'(runLen);
  end

  // Modulo difference against the previous output index.
  logic [IDXW:0] diffWide;
  logic [IDXW-1:0] diffMod;

  always_comb begin
    diffWide = {1'b0, idxNow} + (IDXW+1)'(MODN) - {1'b0, stageIndex};
    if (diffWide >= (IDXW+1)'(MODN)) diffWide = diffWide - (IDXW+1)'(MODN);
    diffMod = diffWide[IDXW-1:0];
  end

  always_ff @(posedge smpClk) begin
    if (smpRst) begin
      stageIndex <= '0;
      edgeDelta  <= '0;
      codeError  <= 1'b0;
    end else if (ctrl.capEn) begin
      stageIndex <= idxNow;
      edgeDelta  <= ctrl.armed ? diffMod : '0;
      codeError  <= ~legalNow;
    end
  end

endmodule

// File: rtl/ring_edge_sampler.sv
`timescale 1ns/1ps
module ring_edge_sampler
  import ring_sense_pkg::*;
#(
  parameter int STAGES     = 8,
  parameter int SYNC_DEPTH = 2,
  localparam int IDXW      = $clog2(2 * STAGES)
) (
  input  logic            oscClk,
  input  logic            oscRst,
  input  logic            smpClk,
  input  logic            smpRst,
  output logic [IDXW-1:0] stageIndex,
  output logic [IDXW-1:0] edgeDelta,
  output logic            deltaValid,
  output logic            codeError
);

  logic [STAGES-1:0] ringState;
  smpCtrl_t          ctrl;

  twisted_ring #(.STAGES(STAGES)) u_ring (
    .oscClk    (oscClk),
    .oscRst    (oscRst),
    .ringState (ringState)
  );

  sense_control #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .smpClk     (smpClk),
    .smpRst     (smpRst),
    .ctrl       (ctrl),
    .deltaValid (deltaValid)
  );

  sense_datapath #(.STAGES(STAGES), .SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .smpClk     (smpClk),
    .smpRst     (smpRst),
    .ringAsync  (ringState),
    .ctrl       (ctrl),
    .stageIndex (stageIndex),
    .edgeDelta  (edgeDelta),
    .codeError  (codeError)
  );

endmodule

// File: rtl/ring_edge_sampler_chk.sv
`timescale 1ns/1ps
module ring_edge_sampler_chk #(
  parameter int STAGES = 8,
  parameter int IDXW   = 4
) (
  input logic              oscClk,
  input logic              oscRst,
  input logic              smpClk,
  input logic              smpRst,
  input logic [STAGES-1:0] ringState,
  input logic [IDXW-1:0]   stageIndex,
  input logic [IDXW-1:0]   edgeDelta,
  input logic              deltaValid,
  input logic              codeError
);

  // R1: ring is all zero on the first edge after reset
  a_r1_ring_zero: assert property (@(posedge oscClk) disable iff (oscRst)
    $past(oscRst) |-> (ringState == '0));

  // R2: exactly one stage changes per oscillator edge
  a_r2_single_flip: assert property (@(posedge oscClk) disable iff (oscRst)
    !$past(oscRst) |-> ($countones(ringState ^ $past(ringState)) == 1));

  // R2: stage 0 takes the inverse of the last stage
  a_r2_feedback: assert property (@(posedge oscClk) disable iff (oscRst)
    !$past(oscRst) |-> (ringState[0] == !$past(ringState[STAGES-1])));

  // R5: reported difference agrees with successive indices
  a_r5_delta_tracks: assert property (@(posedge smpClk) disable iff (smpRst)
    deltaValid |-> (edgeDelta == IDXW'(stageIndex - $past(stageIndex))));

  // R6: once valid, stays valid until reset
  a_r6_valid_holds: assert property (@(posedge smpClk) disable iff (smpRst)
    deltaValid |=> deltaValid);

  // R6: difference is zero while not valid
  a_r6_delta_quiet: assert property (@(posedge smpClk) disable iff (smpRst)
    !deltaValid |-> (edgeDelta == '0));

  // R7: a ring that only ever holds legal codes raises no error
  a_r7_no_error: assert property (@(posedge smpClk) disable iff (smpRst)
    !codeError);

endmodule

bind ring_edge_sampler ring_edge_sampler_chk #(.STAGES(STAGES), .IDXW(IDXW)) u_chk (
  .oscClk     (oscClk),
  .oscRst     (oscRst),
  .smpClk     (smpClk),
  .smpRst     (smpRst),
  .ringState  (ringState),
  .stageIndex (stageIndex),
  .edgeDelta  (edgeDelta),
  .deltaValid (deltaValid),
  .codeError  (codeError)
);

// File: tb/ring_edge_sampler_bench.sv
`timescale 1ns/1ps
module ring_edge_sampler_bench;

  localparam int MODN    = 16;  // 2 * 8 stages
  localparam int LATENCY = 2;   // synchronizer depth
  localparam int VALIDAT = 4;   // first sample edge with valid high

  logic oscClk = 1'b0;
  logic smpClk = 1'b0;
  logic oscRst = 1'b1;
  logic smpRst = 1'b1;
  logic [3:0] stageIndex, edgeDelta;
  logic deltaValid, codeError;

  realtime oscHalf = 0.35;
  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  string curTag = "R1";

  ring_edge_sampler u_ring_edge_sampler (
    .oscClk(oscClk), .oscRst(oscRst), .smpClk(smpClk), .smpRst(smpRst),
    .stageIndex(stageIndex), .edgeDelta(edgeDelta),
    .deltaValid(deltaValid), .codeError(codeError)
  );

  // 100 MHz sampling clock: rising edges at 5 + 10k ns.
  always #5 smpClk = ~smpClk;

  // Oscillator: all half periods are multiples of 50 ps and the start is
  // offset by 23 ps, so no oscillator edge meets a sampling edge.
  initial begin
    #0.023;
    forever begin
      oscClk = 1'b1; #(oscHalf);
      oscClk = 1'b0; #(oscHalf);
    end
  end

  // Behavioural model: edge counter in the oscillator domain.
  int oscCnt = 0;
  always @(posedge oscClk) begin
    if (oscRst) oscCnt = 0;
    else        oscCnt = oscCnt + 1;
  end

  // Captures taken at each sampling edge since the sampling reset.
  int edgeN = 0;
  int capHist[$];
  always @(posedge smpClk) begin
    if (smpRst) begin
      edgeN = 0;
      capHist.delete();
    end else begin
      edgeN = edgeN + 1;
      capHist.push_back(oscCnt % MODN);
    end
  end

  function automatic int capAt(int k);
    return (k < 1) ? 0 : capHist[k-1];
  endfunction

  task automatic check(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) at %0t: actual=%0d expected=%0d", what, curTag, $time, act, exp);
    end
  endtask

  // Compare on every sampling clock, away from the active edge.
  always @(negedge smpClk) begin
    if (!done) begin
      int expIdx, expDelta;
      bit expValid;
      expIdx   = capAt(edgeN - LATENCY);
      expValid = (edgeN >= VALIDAT);
      expDelta = expValid ? ((expIdx - capAt(edgeN - LATENCY - 1) + MODN) % MODN) : 0;
      check("R3 R4 stageIndex", int'(stageIndex), expIdx);
      check("R6 deltaValid", int'(deltaValid), int'(expValid));
      check("R5 edgeDelta", int'(edgeDelta), expDelta);
      check("R7 codeError", int'(codeError), 0);
    end
  end

  initial begin
    repeat (3) @(negedge smpClk);          // reset state checked here (R1)
    oscRst = 1'b0;
    smpRst = 1'b0;
    repeat (12) @(negedge smpClk);         // R1 count from zero, R6 warm-up
    curTag = "R3";  oscHalf = 0.35; repeat (30) @(negedge smpClk);
    curTag = "R5";  oscHalf = 0.45; repeat (30) @(negedge smpClk);
    curTag = "R2";  oscHalf = 5.0;  repeat (20) @(negedge smpClk);   // one edge per sample
    curTag = "R8";  oscHalf = 0.3;  repeat (20) @(negedge smpClk);   // ~16.7 edges per sample
    oscHalf = 0.25;                 repeat (20) @(negedge smpClk);   // 20 edges per sample
    curTag = "R9";  oscHalf = 0.4;  repeat (10) @(negedge smpClk);
    oscRst = 1'b1;                  repeat (3)  @(negedge smpClk);
    oscRst = 1'b0;                  repeat (15) @(negedge smpClk);
    curTag = "R6";  smpRst = 1'b1;  repeat (2)  @(negedge smpClk);
    smpRst = 1'b0;                  repeat (15) @(negedge smpClk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule